// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block is the bit layer of an I2C master. A byte sequencer above it hands over one bus action at a time: start, repeated start, stop, write one bit, or read one bit. The engine then drives the open-drain SCL and SDA pull enables. Every edge is placed so that the minimum low, high, setup, hold and bus-free intervals of the selected speed are met. Those intervals cover standard mode (100 kbit/s class) and fast mode (400 kbit/s class). Acknowledge handling is done by the byte layer: it issues a read bit to sample the acknowledge, or a write bit to send one.

Both bus inputs pass through a synchronizer and a spike filter before the engine uses them. When the engine releases SCL, it waits until the filtered SCL actually reads high and only then times the high phase. This lets a slave stretch the clock.

Between commands the engine normally leaves SCL held low, because every command except stop ends with an SCL fall followed by the SDA hold time. After a stop, both lines stay released. A following start is delayed until the bus-free time has passed.

Top module: `i2c_bit_engine`

## Requirements
- R1: During and after reset, with no command given, both pull enables are released (1), `cmd_ready_o` is 1 and `done_o` is 0.
- R2: A command is taken in a cycle where `cmd_valid_i` and `cmd_ready_o` are both 1. The command codes are 0 start, 1 repeated start, 2 stop, 3 write bit, 4 read bit. Ready is 0 from the next cycle until the command finishes. Each command produces exactly one `done_o` pulse, one cycle long.
- R3: The engine holds SCL pulled low for at least 4.7 µs in standard mode and 1.3 µs in fast mode. After SCL reads high, the engine does not pull it low again for at least 4 µs in standard mode and 0.6 µs in fast mode.
- R4: A start (or repeated start) pulls SDA low while SCL is high. SCL then stays high for at least 4 µs in standard mode and 0.6 µs in fast mode before it is pulled low.
- R5: Before a start, SCL has been high for at least 4.7 µs in standard mode and 0.6 µs in fast mode when SDA falls.
- R6: A stop releases SDA only after SCL has been high for at least 4 µs in standard mode and 0.6 µs in fast mode.
- R7: After a stop, SDA does not fall for a new start until the bus has been free for at least 4.7 µs in standard mode and 1.3 µs in fast mode.
- R8: While SCL is low, SDA changes no sooner than 300 ns after the SCL fall.
- R9: SDA holds its new value for at least 250 ns in standard mode and 100 ns in fast mode before SCL rises.
- R10: The high-phase timing starts only once the filtered SCL input reads high. An external device holding SCL low delays the bit. An SCL pulse of 50 ns or less is ignored.
- R11: A read bit releases SDA. When the bit is done, `rd_bit_o` holds the SDA level sampled in the middle of the SCL high phase.
- R12: The pull enables are active low: 0 pulls the line low and 1 releases it, so the engine never drives a line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | 1 selects fast-mode intervals, 0 selects standard mode |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_i | input | 3 | Command code |
| wr_bit_i | input | 1 | Data bit for a write command |
| done_o | output | 1 | One-cycle pulse when a command completes |
| rd_bit_o | output | 1 | SDA level sampled by the last read bit |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_pull_no | output | 1 | 0 pulls SCL low, 1 releases it |
| sda_pull_no | output | 1 | 0 pulls SDA low, 1 releases it |

## Verification
The interval checks assume that `fast_mode_i` changes only while the engine is idle after a stop. They also assume commands come in a legal bus order: a start first, bits and repeated starts inside a transfer, and a stop to close it. Other devices on the bus are assumed only to stretch SCL low and to change SDA while SCL is low. The bench keeps within these assumptions. It runs all standard-mode traffic before switching to fast mode, changes the slave's SDA level only while the engine is idle with SCL low, and holds SCL low only just after the engine releases it. One of those holds includes a short high spike, so the filter is exercised inside the assumed envelope.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam int unsigned TIM_W = 16;
  localparam int unsigned CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_START   = 3'd0,
    CMD_RESTART = 3'd1,
    CMD_STOP    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_READ    = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [TIM_W-1:0] low;
    logic [TIM_W-1:0] low_rest;
    logic [TIM_W-1:0] high_a;
    logic [TIM_W-1:0] high_b;
    logic [TIM_W-1:0] hd_sta;
    logic [TIM_W-1:0] su_sta;
    logic [TIM_W-1:0] su_sto;
    logic [TIM_W-1:0] buf_free;
    logic [TIM_W-1:0] hd_dat;
  } tim_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic tim_t mode_tim(input bit fast, input int unsigned mhz);
    tim_t t;
    int unsigned lo, hi, su, hd;
    lo = ns2cyc(fast ? 1300 : 4700, mhz);
    hi = ns2cyc(fast ? 600 : 4000, mhz);
    su = ns2cyc(fast ? 100 : 250, mhz);
    hd = ns2cyc(300, mhz);
    t.low      = TIM_W'(lo);
    // remaining low time after the hold, never below data setup
    t.low_rest = TIM_W'((lo > hd + su) ? lo - hd : su);
    t.high_a   = TIM_W'(hi / 2);
    t.high_b   = TIM_W'(hi - hi / 2);
    t.hd_sta   = TIM_W'(ns2cyc(fast ? 600 : 4000, mhz));
    t.su_sta   = TIM_W'(ns2cyc(fast ? 600 : 4700, mhz));
    t.su_sto   = TIM_W'(ns2cyc(fast ? 600 : 4000, mhz));
    t.buf_free = TIM_W'(ns2cyc(fast ? 1300 : 4700, mhz));
    t.hd_dat   = TIM_W'(hd);
    return t;
  endfunction

endpackage

// File: rtl/i2c_bit_timing.sv
module i2c_bit_timing
  import i2c_bit_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 125
) (
  input  logic fast_i,
  output tim_t tim_o
);

  localparam int unsigned N_MODES = 2;

  tim_t mode_set [N_MODES];

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    assign mode_set[m] = mode_tim(m == 1, CLK_MHZ);
  end

  assign tim_o = mode_set[fast_i];

endmodule

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_CYC = 7,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      flt_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == flt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        flt_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = flt_q;

  // R10
  flt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> ($past(sync_q[1]) == flt_q));

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned SPIKE_NS = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_mode_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             wr_bit_i,
  output logic             done_o,
  output logic             rd_bit_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull_no,
  output logic             sda_pull_no
);

  localparam int unsigned SPIKE_CYC = ns2cyc(SPIKE_NS, CLK_MHZ);
  localparam int unsigned FILT_CYC  = (SPIKE_CYC < 1) ? 1 : SPIKE_CYC;
  localparam int unsigned N_LINES   = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_HD_STA, S_LOW, S_WAIT_HI,
    S_HIGH1, S_HIGH2, S_SU_STA, S_SU_STO, S_HD_DAT
  } state_e;

  tim_t tim;
  i2c_bit_timing #(.CLK_MHZ(CLK_MHZ)) u_timing (.fast_i(fast_mode_i), .tim_o(tim));

  logic [N_LINES-1:0] raw, flt;
  logic scl_f, sda_f;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_flt
    i2c_line_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (flt[g])
    );
  end
  assign scl_f = flt[0];
  assign sda_f = flt[1];

  logic             ph_ld, ph_exp, bus_ld, bus_exp;
  logic [TIM_W-1:0] ph_val;

  i2c_phase_timer #(.W(TIM_W)) u_ph_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_ld), .val_i(ph_val), .expired_o(ph_exp));

  i2c_phase_timer #(.W(TIM_W)) u_bus_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(bus_ld), .val_i(tim.buf_free), .expired_o(bus_exp));

  state_e state_q, state_d;
  cmd_e   cmd_q, cmd_d;
  logic   scl_q, scl_d, sda_q, sda_d, rd_q, rd_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    ph_ld   = 1'b0;
    ph_val  = '0;
    bus_ld  = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) begin
        cmd_d = cmd_e'(cmd_i);
        case (cmd_e'(cmd_i))
          CMD_START:   state_d = S_FREE;
          CMD_RESTART: begin sda_d = 1'b1;     ph_ld = 1'b1; ph_val = tim.low_rest; state_d = S_LOW; end
          CMD_STOP:    begin sda_d = 1'b0;     ph_ld = 1'b1; ph_val = tim.low_rest; state_d = S_LOW; end
          CMD_WRITE:   begin sda_d = wr_bit_i; ph_ld = 1'b1; ph_val = tim.low_rest; state_d = S_LOW; end
          CMD_READ:    begin sda_d = 1'b1;     ph_ld = 1'b1; ph_val = tim.low_rest; state_d = S_LOW; end
          default:     state_d = S_IDLE;
        endcase
      end
      S_FREE: if (bus_exp && scl_f && sda_f) begin
        sda_d = 1'b0; ph_ld = 1'b1; ph_val = tim.hd_sta; state_d = S_HD_STA;
      end
      S_HD_STA: if (ph_exp) begin
        scl_d = 1'b0; ph_ld = 1'b1; ph_val = tim.hd_dat; state_d = S_HD_DAT;
      end
      S_LOW: if (ph_exp) begin
        scl_d = 1'b1; state_d = S_WAIT_HI;
      end
      // high phase starts only once the line really reads high
      S_WAIT_HI: if (scl_f) begin
        ph_ld = 1'b1;
        if (cmd_q == CMD_RESTART)   begin ph_val = tim.su_sta; state_d = S_SU_STA; end
        else if (cmd_q == CMD_STOP) begin ph_val = tim.su_sto; state_d = S_SU_STO; end
        else                        begin ph_val = tim.high_a; state_d = S_HIGH1;  end
      end
      S_HIGH1: if (ph_exp) begin
        rd_d = sda_f; ph_ld = 1'b1; ph_val = tim.high_b; state_d = S_HIGH2;
      end
      S_HIGH2: if (ph_exp) begin
        scl_d = 1'b0; ph_ld = 1'b1; ph_val = tim.hd_dat; state_d = S_HD_DAT;
      end
      S_SU_STA: if (ph_exp) begin
        sda_d = 1'b0; ph_ld = 1'b1; ph_val = tim.hd_sta; state_d = S_HD_STA;
      end
      S_SU_STO: if (ph_exp) begin
        sda_d = 1'b1; bus_ld = 1'b1; done_d = 1'b1; state_d = S_IDLE;
      end
      S_HD_DAT: if (ph_exp) begin
        done_d = 1'b1; state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_START;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign done_o      = done_q;
  assign rd_bit_o    = rd_q;
  assign scl_pull_no = scl_q;
  assign sda_pull_no = sda_q;

  // cycles since the engine last pulled SCL low, for interval checks
  logic [TIM_W-1:0] since_fall_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   since_fall_q <= '1;
    else if (scl_q && !scl_d)      since_fall_q <= '0;
    else if (since_fall_q != '1)   since_fall_q <= since_fall_q + 1'b1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && (cmd_i <= CMD_READ)) |=> !cmd_ready_o);

  // R3
  scl_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_q) |-> (since_fall_q >= tim.low));

  // R8
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_q && !$stable(sda_q)) |-> (since_fall_q >= tim.hd_dat));

endmodule

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;

  localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_STOP = 3'd2,
                         C_WRITE = 3'd3, C_READ = 3'd4;
  localparam int BIG = 1000000;

  logic clk_i = 1'b0, rst_ni = 1'b0, fast_mode_i = 1'b0;
  logic cmd_valid_i = 1'b0, wr_bit_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic cmd_ready_o, done_o, rd_bit_o, scl_pull_no, sda_pull_no;
  logic stretch = 1'b0, slave_pull = 1'b0;
  logic scl_bus, sda_bus;
  int   stretch_len = 0;
  bit   glitch_en = 1'b0;

  assign scl_bus = scl_pull_no & ~stretch;
  assign sda_bus = sda_pull_no & ~slave_pull;

  always #4 clk_i = ~clk_i;

  i2c_bit_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fast_mode_i(fast_mode_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_i(cmd_i),
    .wr_bit_i(wr_bit_i), .done_o(done_o), .rd_bit_o(rd_bit_o),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_pull_no(scl_pull_no), .sda_pull_no(sda_pull_no));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int need(input int ns);
    return (ns * 125 + 999) / 1000;
  endfunction

  typedef struct {logic [2:0] cmd; logic rd;} exp_t;
  exp_t exp_q[$];

  // driver: offers one command, pushes its expected result
  task automatic do_cmd(input logic [2:0] c, input logic wb, input logic slave_low,
                        input int str_len, input bit glitch);
    exp_t e;
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    slave_pull  = slave_low;
    stretch_len = str_len;
    glitch_en   = glitch;
    e.cmd = c; e.rd = ~slave_low;
    exp_q.push_back(e);
    cmd_valid_i = 1'b1; cmd_i = c; wr_bit_i = wb;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(cmd_ready_o == 1'b0, "R2 ready low after accept", int'(cmd_ready_o), 0);
    while (!done_o) @(negedge clk_i);
  endtask

  // other device stretching SCL, optionally with a short spike (R10)
  initial begin
    forever begin
      @(posedge scl_pull_no);
      if (stretch_len > 0) begin
        stretch = 1'b1;
        repeat (stretch_len) @(negedge clk_i);
        if (glitch_en) begin
          stretch = 1'b0;
          repeat (3) @(negedge clk_i);
          stretch = 1'b1;
          repeat (40) @(negedge clk_i);
        end
        stretch = 1'b0;
      end
    end
  end

  // monitor: interval checks and scoreboard pop
  int c_pf = BIG, c_sr = BIG, c_sf = BIG, c_sd = BIG, c_stop = BIG, c_start = BIG;
  int t_low, t_high, t_susta, t_hdsta, t_susto, t_buf, t_hd, t_su;
  bit pend_start = 1'b0;
  logic p_pull = 1'b1, p_scl = 1'b1, p_sda = 1'b1, p_done = 1'b0;
  exp_t got;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_pull = 1'b1; p_scl = 1'b1; p_sda = 1'b1; p_done = 1'b0; pend_start = 1'b0;
    end else begin
      t_low   = fast_mode_i ? need(1300) : need(4700);
      t_high  = fast_mode_i ? need(600)  : need(4000);
      t_susta = fast_mode_i ? need(600)  : need(4700);
      t_hdsta = fast_mode_i ? need(600)  : need(4000);
      t_susto = fast_mode_i ? need(600)  : need(4000);
      t_buf   = fast_mode_i ? need(1300) : need(4700);
      t_su    = fast_mode_i ? need(100)  : need(250);
      t_hd    = need(300);
      c_pf++; c_sr++; c_sf++; c_sd++; c_stop++; c_start++;
      if (!p_pull && scl_pull_no) chk(c_pf >= t_low, "R3 SCL low min", c_pf, t_low);
      if (p_pull && !scl_pull_no) begin
        chk(c_sr >= t_high, "R3 R10 SCL high min", c_sr, t_high);
        c_pf = 0;
      end
      if (p_sda && !sda_bus && scl_bus) begin
        chk(c_sr >= t_susta, "R5 start setup min", c_sr, t_susta);
        chk(c_stop >= t_buf, "R7 bus free min", c_stop, t_buf);
        pend_start = 1'b1; c_start = 0;
      end
      if (!p_sda && sda_bus && scl_bus) begin
        chk(c_sr >= t_susto, "R6 stop setup min", c_sr, t_susto);
        c_stop = 0;
      end
      if ((p_sda != sda_bus) && !scl_bus) chk(c_sf >= t_hd, "R8 SDA hold min", c_sf, t_hd);
      if (p_sda != sda_bus) c_sd = 0;
      if (!p_scl && scl_bus) begin
        chk(c_sd >= t_su, "R9 data setup min", c_sd, t_su);
        c_sr = 0;
      end
      if (p_scl && !scl_bus) begin
        if (pend_start) begin
          chk(c_start >= t_hdsta, "R4 start hold min", c_start, t_hdsta);
          pend_start = 1'b0;
        end
        c_sf = 0;
      end
      if (done_o) begin
        chk(!p_done, "R2 done single cycle", int'(p_done), 0);
        chk(exp_q.size() > 0, "R2 done without command", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          got = exp_q.pop_front();
          if (got.cmd == C_READ)
            chk(rd_bit_o == got.rd, "R11 read bit", int'(rd_bit_o), int'(got.rd));
        end
      end
      p_pull = scl_pull_no; p_scl = scl_bus; p_sda = sda_bus; p_done = done_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 R12 in reset
    chk(scl_pull_no == 1'b1 && sda_pull_no == 1'b1, "R1 R12 lines released in reset",
        int'({scl_pull_no, sda_pull_no}), 3);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1 ready after reset", int'(cmd_ready_o), 1);
    chk(done_o == 1'b0, "R1 no done after reset", int'(done_o), 0);
    chk(scl_pull_no == 1'b1 && sda_pull_no == 1'b1, "R1 lines released after reset",
        int'({scl_pull_no, sda_pull_no}), 3);

    // standard mode
    do_cmd(C_START, 1'b0, 1'b0, 0, 1'b0);
    chk(scl_pull_no == 1'b0 && sda_pull_no == 1'b0, "R4 lines low after start",
        int'({scl_pull_no, sda_pull_no}), 0);
    do_cmd(C_WRITE, 1'b1, 1'b0, 0, 1'b0);
    do_cmd(C_WRITE, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b1, 0, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_RESTART, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_WRITE, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_STOP,  1'b0, 1'b0, 0, 1'b0);
    chk(scl_pull_no == 1'b1 && sda_pull_no == 1'b1, "R6 lines released after stop",
        int'({scl_pull_no, sda_pull_no}), 3);
    do_cmd(C_START, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_STOP,  1'b0, 1'b0, 0, 1'b0);

    // fast mode, with clock stretching
    fast_mode_i = 1'b1;
    do_cmd(C_START, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_WRITE, 1'b1, 1'b0, 0, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b1, 100, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b0, 60, 1'b1);
    do_cmd(C_WRITE, 1'b0, 1'b0, 80, 1'b0);
    do_cmd(C_RESTART, 1'b0, 1'b0, 50, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_READ,  1'b0, 1'b1, 0, 1'b0);
    do_cmd(C_STOP,  1'b0, 1'b0, 30, 1'b0);
    do_cmd(C_START, 1'b0, 1'b0, 0, 1'b0);
    do_cmd(C_STOP,  1'b0, 1'b0, 0, 1'b0);

    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 every command completed", exp_q.size(), 0);
    chk(cmd_ready_o == 1'b1, "R2 idle at end", int'(cmd_ready_o), 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule